// File: doc/BRIEF.md
# Segmented Mismatch-Shaping Current-Pulse DAC Encoder

This block turns one 7-bit integrated error word per reference period into 32 one-bit steering lines: 16 for a bank of coarse unit current-pulse sources and 16 for a bank of fine ones. A coarse unit carries eight times the charge of a fine unit. A line that is high selects a positive pulse and a line that is low selects a negative pulse, so a bank's contribution depends only on how many of its lines are high. The analog sources and the pulse timing sit outside the block.

The word is first split by a first-order delta-sigma stage. The stage adds a carried residue to the input, takes the upper part as a 17-level coarse count, and keeps the lower part as the new residue. The fine bank gets whatever the coarse count leaves over, so the weighted total stays exact. Each count then goes into a four-layer binary tree of splitting nodes. Each node hands half of its count to each of its two subtrees. When the count is odd, the spare unit goes to alternate subtrees on successive odd counts. A pseudorandom bit decides which subtree receives the first spare of each pair. This keeps the cumulative use of every unit source within one unit of the other sources. As a result, mismatch error is pushed to high frequencies and does not settle into a fixed pattern.

Each clock is one reference period. The input sampled at a rising edge appears on the 32 lines right after that edge.

Top module: `segdem_encoder`

## Requirements
- R1: While reset is asserted, all 32 lines are low. After reset is released, the carried residue starts at zero and every tree node starts balanced, so the first input x gives a coarse count of floor(x/8).
- R2: For the input x sampled at an edge, the lines after that edge satisfy 8·Nc + Nf = x + 8, where Nc and Nf are the numbers of high coarse and fine lines. Equivalently, the signed pulse sum equals 2x − 128 fine units.
- R3: The coarse count follows a carried residue r that starts at zero: Nc = floor((x + r)/8), and the next r is (x + r) mod 8.
- R4: The fine count always lies between 1 and 15.
- R5: An input of 0 gives a coarse count of 0. An input of 127 gives a coarse count of 15 or 16, and the coarse count never exceeds 16.
- R6: When the input is held constant, the coarse count changes by at most one from one period to the next.
- R7: Over any run that starts at reset, the number of periods in which any one unit line was high differs from that of any other line in the same bank by at most 2.
- R8: The pseudorandom source that picks the first spare of each pair is never all zeros. Under a constant input, the set of high lines in a bank changes over time even for equal counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference-period clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| level_i | input | 7 | Integrated error word, unsigned, sampled each rising edge |
| coarse_o | output | 16 | Coarse bank steering lines, high = positive pulse |
| fine_o | output | 16 | Fine bank steering lines, high = positive pulse |

## Verification
The properties assume that every clock edge is one reference period and that level_i may take any 7-bit value on any edge. The reconstruction and range properties are therefore checked every cycle without any limit on the input. The coarse-step property is armed only once the input has been equal on two consecutive edges, and the stimulus holds the input constant for long stretches so that this condition arises. The usage-balance requirement holds only for a run that begins at reset, so the bench issues a reset right before the constant-level run it uses to count how often each unit is used.

// File: rtl/segdem_pkg.sv
package segdem_pkg;

    // Per-node memory of which subtree is owed the next spare unit.
    typedef enum logic [1:0] {
        NODE_EVEN  = 2'd0,
        NODE_OWE_A = 2'd1,
        NODE_OWE_B = 2'd2
    } node_mode_e;

    localparam int DEF_IN_W  = 7;
    localparam int DEF_UNITS = 16;
    localparam int DEF_RATIO = 8;

endpackage

// File: rtl/segdem_lfsr.sv
module segdem_lfsr #(
    parameter int          W    = 32,
    parameter logic [W-1:0] TAPS = 32'h80200003,
    parameter logic [W-1:0] SEED = 32'h1ACE5EED
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    output logic [W-1:0] state_o
);

    logic [W-1:0] state_d, state_q;

    always_comb begin
        state_d = state_q >> 1;
        if (state_q[0]) begin
            state_d = state_d ^ TAPS;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= SEED;
        end else begin
            state_q <= state_d;
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/segdem_split.sv
module segdem_split #(
    parameter int IN_W  = 7,
    parameter int RATIO = 8,
    parameter int UNITS = 16,
    localparam int RB   = $clog2(RATIO),
    localparam int CW   = $clog2(UNITS + 1),
    localparam int SW   = IN_W + 1
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [IN_W-1:0] level_i,
    output logic [CW-1:0]   coarse_o,
    output logic [CW-1:0]   fine_o
);

    typedef struct packed {
        logic [RB-1:0] res;
    } split_state_t;

    split_state_t s_d, s_q;
    logic [SW-1:0] sum;

    always_comb begin
        s_d      = s_q;
        sum      = SW'(level_i) + SW'(s_q.res);
        coarse_o = CW'(sum >> RB);
        fine_o   = CW'(RATIO) + CW'(sum[RB-1:0]) - CW'(s_q.res);
        s_d.res  = sum[RB-1:0];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/segdem_node.sv
module segdem_node
    import segdem_pkg::*;
#(
    parameter int CW        = 5,
    parameter bit RANDOMIZE = 1'b1
) (
    input  logic [CW-1:0] n_i,
    input  node_mode_e    mode_i,
    input  logic          rnd_i,
    output logic [CW-1:0] a_o,
    output logic [CW-1:0] b_o,
    output node_mode_e    mode_o
);

    logic          first_pick;
    logic          give_a;
    logic          odd;
    logic [CW-1:0] half;

    generate
        if (RANDOMIZE) begin : g_rand
            assign first_pick = rnd_i;
        end else begin : g_fixed
            assign first_pick = 1'b1;
        end
    endgenerate

    always_comb begin
        half = n_i >> 1;
        odd  = n_i[0];
        unique case (mode_i)
            NODE_OWE_A: give_a = 1'b1;
            NODE_OWE_B: give_a = 1'b0;
            default:    give_a = first_pick;
        endcase
        a_o    = half + CW'(odd & give_a);
        b_o    = half + CW'(odd & ~give_a);
        mode_o = mode_i;
        if (odd) begin
            if (mode_i == NODE_EVEN) begin
                mode_o = give_a ? NODE_OWE_B : NODE_OWE_A;
            end else begin
                mode_o = NODE_EVEN;
            end
        end
    end

endmodule

// File: rtl/segdem_tree.sv
module segdem_tree
    import segdem_pkg::*;
#(
    parameter int UNITS     = 16,
    parameter bit RANDOMIZE = 1'b1,
    localparam int NODES    = UNITS - 1,
    localparam int HEAP     = 2 * UNITS - 1,
    localparam int CW       = $clog2(UNITS + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [CW-1:0]    level_i,
    input  logic [NODES-1:0] rnd_i,
    output logic [UNITS-1:0] bits_o
);

    typedef struct packed {
        logic [NODES-1:0][1:0] mode;
        logic [UNITS-1:0]      bits;
    } tree_state_t;

    tree_state_t s_d, s_q;
    logic [CW-1:0] cnt [HEAP];
    node_mode_e    mode_nx [NODES];

    assign cnt[0] = level_i;

    // Heap layout: node i feeds slots 2i+1 and 2i+2; leaves sit above NODES-1.
    generate
        for (genvar i = 0; i < NODES; i++) begin : g_node
            segdem_node #(
                .CW       (CW),
                .RANDOMIZE(RANDOMIZE)
            ) node_i (
                .n_i   (cnt[i]),
                .mode_i(node_mode_e'(s_q.mode[i])),
                .rnd_i (rnd_i[i]),
                .a_o   (cnt[2*i+1]),
                .b_o   (cnt[2*i+2]),
                .mode_o(mode_nx[i])
            );
        end
    endgenerate

    always_comb begin
        s_d = s_q;
        for (int i = 0; i < NODES; i++) begin
            s_d.mode[i] = mode_nx[i];
        end
        for (int j = 0; j < UNITS; j++) begin
            s_d.bits[j] = (cnt[NODES+j] != '0);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign bits_o = s_q.bits;

endmodule

// File: rtl/segdem_encoder.sv
module segdem_encoder
    import segdem_pkg::*;
#(
    parameter int               IN_W      = DEF_IN_W,
    parameter int               UNITS     = DEF_UNITS,
    parameter int               RATIO     = DEF_RATIO,
    parameter bit               RANDOMIZE = 1'b1,
    parameter int               LFSR_W    = 32,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = 32'h80200003,
    parameter logic [LFSR_W-1:0] LFSR_SEED = 32'h1ACE5EED
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [IN_W-1:0]  level_i,
    output logic [UNITS-1:0] coarse_o,
    output logic [UNITS-1:0] fine_o
);

    localparam int NODES = UNITS - 1;
    localparam int RNDS  = 2 * NODES;
    localparam int CW    = $clog2(UNITS + 1);

    logic [LFSR_W-1:0] lfsr_q;
    logic [RNDS-1:0]   rnd_all;
    logic [CW-1:0]     lvl_c;
    logic [CW-1:0]     lvl_f;

    segdem_lfsr #(
        .W   (LFSR_W),
        .TAPS(LFSR_TAPS),
        .SEED(LFSR_SEED)
    ) lfsr_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .state_o(lfsr_q)
    );

    // Fold every LFSR bit onto the node decision bits.
    always_comb begin
        rnd_all = '0;
        for (int k = 0; k < LFSR_W; k++) begin
            rnd_all[k % RNDS] = rnd_all[k % RNDS] ^ lfsr_q[k];
        end
    end

    segdem_split #(
        .IN_W (IN_W),
        .RATIO(RATIO),
        .UNITS(UNITS)
    ) split_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .level_i (level_i),
        .coarse_o(lvl_c),
        .fine_o  (lvl_f)
    );

    segdem_tree #(
        .UNITS    (UNITS),
        .RANDOMIZE(RANDOMIZE)
    ) coarse_tree_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .level_i(lvl_c),
        .rnd_i  (rnd_all[NODES-1:0]),
        .bits_o (coarse_o)
    );

    segdem_tree #(
        .UNITS    (UNITS),
        .RANDOMIZE(RANDOMIZE)
    ) fine_tree_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .level_i(lvl_f),
        .rnd_i  (rnd_all[RNDS-1:NODES]),
        .bits_o (fine_o)
    );

endmodule

// File: rtl/segdem_encoder_chk.sv
module segdem_encoder_chk #(
    parameter int IN_W   = 7,
    parameter int UNITS  = 16,
    parameter int RATIO  = 8,
    parameter int LFSR_W = 32
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [IN_W-1:0]   level_i,
    input logic [UNITS-1:0]  coarse_o,
    input logic [UNITS-1:0]  fine_o,
    input logic [LFSR_W-1:0] lfsr_state
);

    logic armed1_q, armed2_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            armed1_q <= 1'b0;
            armed2_q <= 1'b0;
        end else begin
            armed1_q <= 1'b1;
            armed2_q <= armed1_q;
        end
    end

    a_r2_exact_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
        armed1_q |-> (RATIO * $countones(coarse_o) + $countones(fine_o))
                     == (int'($past(level_i)) + RATIO));

    a_r4_fine_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
        armed1_q |-> ($countones(fine_o) >= 1 && $countones(fine_o) <= 2 * RATIO - 1));

    a_r5_zero_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed1_q && $past(level_i) == '0) |-> ($countones(coarse_o) == 0));

    a_r6_coarse_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed2_q && $past(level_i) == $past(level_i, 2))
        |-> (($countones(coarse_o) - $past($countones(coarse_o))) <= 1 &&
             ($past($countones(coarse_o)) - $countones(coarse_o)) <= 1));

    a_r8_lfsr_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lfsr_state != '0);

endmodule

bind segdem_encoder segdem_encoder_chk #(
    .IN_W  (IN_W),
    .UNITS (UNITS),
    .RATIO (RATIO),
    .LFSR_W(LFSR_W)
) chk_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .level_i   (level_i),
    .coarse_o  (coarse_o),
    .fine_o    (fine_o),
    .lfsr_state(lfsr_q)
);

// File: tb/segdem_encoder_tb_top.sv
`timescale 1ns/1ps
module segdem_encoder_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  level = '0;
    logic [15:0] coarse;
    logic [15:0] fine;

    int checks = 0;
    int errors = 0;
    int res_m  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    // {input, expected coarse count, expected fine count}, starting from reset.
    localparam logic [23:0] VEC [12] = '{
        24'h000008, 24'h7F0F0F, 24'h7F1007, 24'h400808,
        24'h010009, 24'h010101, 24'h640C0C, 24'h03000B,
        24'h090201, 24'h4D090D, 24'h32060A, 24'h7E1006
    };

    always #10 clk = ~clk;

    segdem_encoder dut_i (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .level_i (level),
        .coarse_o(coarse),
        .fine_o  (fine)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive at a falling edge; outputs are read at the next falling edge.
    task automatic step(input int x);
        int s;
        level = 7'(x);
        @(negedge clk);
        s = x + res_m;
        res_m = s % 8;
    endtask

    task automatic step_model(input int x);
        int ec;
        ec = (x + res_m) / 8;
        step(x);
        check("R3 coarse count", $countones(coarse), ec);
        check("R2 weighted sum", 8 * $countones(coarse) + $countones(fine), x + 8);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int cnt_c [16];
        int cnt_f [16];
        int prev_c;
        int mx, mn;
        logic [15:0] first_pat;
        bit pat_changed;

        repeat (3) @(negedge clk);
        check("R1 coarse low in reset", int'(coarse), 0);
        check("R1 fine low in reset", int'(fine), 0);
        rst_n = 1'b1;
        res_m = 0;

        // Table of vectors from reset.
        for (int i = 0; i < 12; i++) begin
            step(int'(VEC[i][23:16]));
            check("R3 table coarse", $countones(coarse), int'(VEC[i][15:8]));
            check("R4 table fine", $countones(fine), int'(VEC[i][7:0]));
            check("R2 table sum", 8 * $countones(coarse) + $countones(fine),
                  int'(VEC[i][23:16]) + 8);
        end

        // Varied sweep against the residue model.
        for (int k = 0; k < 400; k++) begin
            step_model((k * 37 + 11) % 128);
            checks++;
            if ($countones(fine) < 1 || $countones(fine) > 15) begin
                errors++;
                $display("FAIL R4 fine range: actual %0d expected 1..15", $countones(fine));
            end
        end

        // Extremes.
        for (int k = 0; k < 16; k++) begin
            step_model(127);
            checks++;
            if ($countones(coarse) < 15) begin
                errors++;
                $display("FAIL R5 full input: actual %0d expected >=15", $countones(coarse));
            end
        end
        for (int k = 0; k < 8; k++) begin
            step_model(0);
            check("R5 zero input coarse", $countones(coarse), 0);
        end

        // Reset in mid-run, then residue cleared.
        step_model(13);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 coarse cleared by reset", int'(coarse), 0);
        check("R1 fine cleared by reset", int'(fine), 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        res_m = 0;
        step(5);
        check("R1 residue zero after reset", $countones(coarse), 0);
        check("R1 fine after reset", $countones(fine), 13);

        // Constant-level usage run from reset.
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        res_m = 0;
        for (int j = 0; j < 16; j++) begin
            cnt_c[j] = 0;
            cnt_f[j] = 0;
        end
        prev_c = -1;
        first_pat = '0;
        pat_changed = 1'b0;
        for (int k = 0; k < 600; k++) begin
            step_model(37);
            for (int j = 0; j < 16; j++) begin
                cnt_c[j] += int'(coarse[j]);
                cnt_f[j] += int'(fine[j]);
            end
            if (prev_c >= 0) begin
                checks++;
                if ($countones(coarse) - prev_c > 1 || prev_c - $countones(coarse) > 1) begin
                    errors++;
                    $display("FAIL R6 coarse step: actual %0d expected within 1 of %0d",
                             $countones(coarse), prev_c);
                end
            end
            prev_c = $countones(coarse);
            if ($countones(coarse) == 4) begin
                if (first_pat == '0) first_pat = coarse;
                else if (coarse != first_pat) pat_changed = 1'b1;
            end
        end
        mx = cnt_c[0]; mn = cnt_c[0];
        for (int j = 1; j < 16; j++) begin
            if (cnt_c[j] > mx) mx = cnt_c[j];
            if (cnt_c[j] < mn) mn = cnt_c[j];
        end
        checks++;
        if (mx - mn > 2) begin
            errors++;
            $display("FAIL R7 coarse usage spread: actual %0d expected <=2", mx - mn);
        end
        mx = cnt_f[0]; mn = cnt_f[0];
        for (int j = 1; j < 16; j++) begin
            if (cnt_f[j] > mx) mx = cnt_f[j];
            if (cnt_f[j] < mn) mn = cnt_f[j];
        end
        checks++;
        if (mx - mn > 2) begin
            errors++;
            $display("FAIL R7 fine usage spread: actual %0d expected <=2", mx - mn);
        end
        check("R8 pattern varies for equal count", int'(pat_changed), 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule